// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is a register-programmed SPI master that carries out exactly one serial flash transaction for each start command. Software fills a command word, which packs an opcode byte and a 24-bit flash address, and a data word that supplies up to four payload bytes. It then writes a control word that gives the transmit byte count and the receive byte count and sets the start bit. The engine lowers chip select, clocks the transmit bytes out, clocks the receive bytes in, releases chip select, and clears its busy flag.

One 4-bit transmit count covers the opcode, the address and the payload bytes together. Some typical counts:

- A one-byte command such as write enable uses 1 transmit byte and 0 receive bytes.
- A status poll uses 1 transmit byte and 1 receive byte.
- An identification read uses 4 transmit bytes and 1 receive byte.
- A four-byte page program uses 8 transmit bytes and 0 receive bytes.

Received bytes are packed into the data word from bit 0 upward, and software reads them there after busy drops. The serial clock runs in mode 0. Its period is a parameterised even number of system clocks.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, busy reads 0, and the control, command and data registers read 0.
- R2: The register map and the control register layout are as follows.
  - Register address 0 is control: transmit count in bits [3:0], receive count in bits [7:4], start in bit 8 (write only, reads 0) and busy in bit 16 (read only).
  - Register address 1 is the command word and register address 2 is the data word.
  - A control write with bit 8 set launches a transaction, and busy reads 1 from the next cycle until the transaction ends.
- R3: The first transmitted byte is command bits [7:0]. It is followed by command bits [31:24], then [23:16], then [15:8]. Every byte is sent most significant bit first.
- R4: Transmit bytes 5 to 8 come from the data word, least significant byte first. Transmit bytes beyond the eighth are sent as 0x00.
- R5: Receive byte j (counting from 0) is stored in data bits [8j+7:8j], and its first bit received goes to bit 8j+7.
  - Receive bytes beyond the fourth are clocked but dropped.
  - Data bits above the captured bytes read 0 once the transaction ends.
- R6: A transaction with a receive count of 0 leaves the data register unchanged.
- R7: The serial clock follows mode 0.
  - It idles low, and MOSI changes only on its falling edges while chip select is low.
  - Its period is CLK_DIV system clocks.
  - A transaction gives exactly 8 × (transmit + receive) rising edges.
- R8: Chip select stays low from the start until after the last bit. It rises exactly CLK_DIV system clocks after the last falling edge of the serial clock.
- R9: Register writes made while busy are handled as follows.
  - A start while busy is ignored.
  - Writes to the command, data or control register while busy update those registers but do not alter the bytes, counts or length of the transaction in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench drives a behavioural flash model that records every MOSI bit on rising edges. The same model returns a position-dependent byte pattern on MISO, so a byte placed in the wrong lane or shifted by one bit shows up directly.

The count pairs cover these cases:
- Transmit-only 1/0 and 8/0 separate opcode placement from address order and payload order.
- The pairs 1/1, 4/1 and 4/4 show where captured bytes land and that untouched upper bits are zeroed.
- The pair 1/6 shows that bytes past the fourth are dropped.
- The pair 10/0 shows zero fill past the eighth transmit byte.

A final case writes every register and requests a new start in the middle of a transfer. It checks that the serial stream, the edge count and the single chip-select pulse still belong to the original request.

// File: rtl/spi_cmd_pkg.sv
`timescale 1ns/1ps
package spi_cmd_pkg;

    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_CMD  = 2'd1;
    localparam logic [1:0] RA_DATA = 2'd2;

    localparam int CTRL_START_BIT = 8;
    localparam int CNT_W          = 4;
    localparam int BITCNT_W       = 8;
    localparam int TXV_W          = 64;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_TAIL = 2'd2
    } eng_state_t;

    typedef struct packed {
        eng_state_t            st;
        logic                  sclk;
        logic                  half;
        logic [TXV_W-1:0]      txv;
        logic [31:0]           rxw;
        logic [BITCNT_W-1:0]   bit_cnt;
        logic [BITCNT_W-1:0]   total;
        logic [BITCNT_W-1:0]   tx_bits;
        logic [CNT_W-1:0]      rxn;
    } eng_t;

    typedef struct packed {
        logic [7:0]  ctrl;
        logic [31:0] cmd;
        logic [31:0] data;
    } regs_t;

endpackage

// File: rtl/spi_sclk_timer.sv
`timescale 1ns/1ps
module spi_sclk_timer #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int HALF = CLK_DIV / 2;
    localparam int CW   = $clog2(HALF) + 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == CW'(HALF - 1));
        cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0)); // R7
endmodule

// File: rtl/spi_shift_engine.sv
`timescale 1ns/1ps
module spi_shift_engine
    import spi_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic [CNT_W-1:0] tx_cnt,
    input  logic [CNT_W-1:0] rx_cnt,
    input  logic [31:0]      cmd,
    input  logic [31:0]      data,
    input  logic             miso,
    output logic             busy,
    output logic             cs_n,
    output logic             sclk,
    output logic             mosi,
    output logic             done,
    output logic             rx_used,
    output logic [31:0]      rx_word
);
    eng_t q, d;
    logic [BITCNT_W-1:0] rel;
    logic [BITCNT_W-1:0] nxt_bit;
    logic [CNT_W:0]      sum_cnt;

    always_comb begin
        d       = q;
        done    = 1'b0;
        rel     = q.bit_cnt - q.tx_bits;
        nxt_bit = q.bit_cnt + 1'b1;
        sum_cnt = {1'b0, tx_cnt} + {1'b0, rx_cnt};
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st      = (sum_cnt == '0) ? ST_TAIL : ST_XFER;
                    d.txv     = {cmd[7:0], cmd[31:24], cmd[23:16], cmd[15:8],
                                 data[7:0], data[15:8], data[23:16], data[31:24]};
                    d.rxw     = '0;
                    d.bit_cnt = '0;
                    d.total   = BITCNT_W'({sum_cnt, 3'b000});
                    d.tx_bits = BITCNT_W'({tx_cnt, 3'b000});
                    d.rxn     = rx_cnt;
                    d.sclk    = 1'b0;
                    d.half    = 1'b0;
                end
            end
            ST_XFER: begin
                if (tick) begin
                    if (!q.sclk) begin
                        d.sclk = 1'b1;
                        if ((q.bit_cnt >= q.tx_bits) && (rel < BITCNT_W'(32)))
                            d.rxw[{rel[4:3], ~rel[2:0]}] = miso;
                    end else begin
                        d.sclk    = 1'b0;
                        d.bit_cnt = nxt_bit;
                        if (nxt_bit == q.total) begin
                            d.st   = ST_TAIL;
                            d.half = 1'b0;
                        end else begin
                            d.txv = {q.txv[TXV_W-2:0], 1'b0};
                        end
                    end
                end
            end
            ST_TAIL: begin
                if (tick) begin
                    if (q.half) begin
                        d.st = ST_IDLE;
                        done = 1'b1;
                    end else begin
                        d.half = 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy    = (q.st != ST_IDLE);
    assign cs_n    = (q.st == ST_IDLE);
    assign sclk    = q.sclk;
    assign mosi    = (q.st == ST_XFER) && q.txv[TXV_W-1];
    assign rx_used = (q.rxn != '0);
    assign rx_word = q.rxw;

    AST_SCLK_LOW_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk); // R7
    AST_MOSI_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n) && !$fell(sclk)) |-> $stable(mosi)); // R7
    AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(q.total) && $stable(q.tx_bits))); // R9
    AST_BITS_WITHIN_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> (q.bit_cnt <= q.total)); // R7
endmodule

// File: rtl/spi_cmd_engine.sv
`timescale 1ns/1ps
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        spi_cs_n,
    output logic        spi_sclk,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    regs_t q, d;
    logic        tick, busy, done, rx_used, start;
    logic [31:0] rx_word;

    assign start = reg_we && (reg_addr == RA_CTRL) && reg_wdata[CTRL_START_BIT];

    spi_sclk_timer #(.CLK_DIV(CLK_DIV)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .tick (tick)
    );

    spi_shift_engine u_engine (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .start  (start),
        .tx_cnt (reg_wdata[3:0]),
        .rx_cnt (reg_wdata[7:4]),
        .cmd    (q.cmd),
        .data   (q.data),
        .miso   (spi_miso),
        .busy   (busy),
        .cs_n   (spi_cs_n),
        .sclk   (spi_sclk),
        .mosi   (spi_mosi),
        .done   (done),
        .rx_used(rx_used),
        .rx_word(rx_word)
    );

    always_comb begin
        d = q;
        if (reg_we) begin
            case (reg_addr)
                RA_CTRL: d.ctrl = reg_wdata[7:0];
                RA_CMD:  d.cmd  = reg_wdata;
                RA_DATA: d.data = reg_wdata;
                default: ;
            endcase
        end
        if (done && rx_used) d.data = rx_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (reg_addr)
            RA_CTRL: reg_rdata = {15'd0, busy, 8'd0, q.ctrl};
            RA_CMD:  reg_rdata = q.cmd;
            RA_DATA: reg_rdata = q.data;
            default: reg_rdata = '0;
        endcase
    end

    AST_DATA_HOLD_NO_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (!(reg_we && reg_addr == RA_DATA) && !(done && rx_used)) |=> $stable(q.data)); // R6
    AST_CMD_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr == RA_CMD) |=> $stable(q.cmd)); // R2
endmodule

// File: tb/spi_cmd_engine_bench.sv
`timescale 1ns/1ps
module spi_cmd_engine_bench;
    localparam int CLK_DIV = 4;
    localparam realtime TCLK = 10.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        spi_cs_n, spi_sclk, spi_mosi;
    logic        spi_miso = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    spi_cmd_engine #(.CLK_DIV(CLK_DIV)) u_spi_cmd_engine (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_cs_n(spi_cs_n),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // ---------------- flash model ----------------
    logic [7:0] got [0:31];
    int nbits = 0, cs_falls = 0;
    realtime t_rise0, t_rise1, t_last_fall, t_cs_rise;

    function automatic logic [7:0] resp_byte(input int k);
        return 8'(8'hC3 ^ (k * 37));
    endfunction

    function automatic logic resp_bit(input int n);
        logic [7:0] b;
        b = resp_byte(n / 8);
        return b[7 - (n % 8)];
    endfunction

    always @(negedge spi_cs_n) begin
        nbits = 0;
        cs_falls++;
        for (int i = 0; i < 32; i++) got[i] = 8'h00;
        spi_miso = resp_bit(0);
    end

    always @(posedge spi_sclk) begin
        if (nbits == 0) t_rise0 = $realtime;
        if (nbits == 1) t_rise1 = $realtime;
        if (nbits < 256) got[nbits / 8][7 - (nbits % 8)] = spi_mosi;
        nbits++;
    end

    always @(negedge spi_sclk) begin
        t_last_fall = $realtime;
        spi_miso = resp_bit(nbits);
    end

    always @(posedge spi_cs_n) t_cs_rise = $realtime;

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        int n = 0;
        do begin
            rd(2'd0, v);
            n++;
        end while (v[16] && n < 5000);
        chk(n < 5000, "R2", "busy never cleared", v, 32'h0);
    endtask

    function automatic logic [7:0] exp_tx(input logic [31:0] c, input logic [31:0] dt, input int i);
        case (i)
            0: return c[7:0];
            1: return c[31:24];
            2: return c[23:16];
            3: return c[15:8];
            4: return dt[7:0];
            5: return dt[15:8];
            6: return dt[23:16];
            7: return dt[31:24];
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [31:0] exp_rx(input int tx, input int rx);
        logic [31:0] w = '0;
        for (int j = 0; j < rx && j < 4; j++) w[j*8 +: 8] = resp_byte(tx + j);
        return w;
    endfunction

    task automatic launch(input int tx, input int rx);
        logic [31:0] v;
        cs_falls = 0;
        wr(2'd0, 32'h100 | 32'(rx << 4) | 32'(tx));
        rd(2'd0, v);
        chk(v[16] == 1'b1, "R2", "busy after start", {31'd0, v[16]}, 32'h1);
        chk(spi_cs_n == 1'b0, "R8", "cs low after start", {31'd0, spi_cs_n}, 32'h0);
    endtask

    task automatic finish(input int tx, input int rx, input logic [31:0] c,
                          input logic [31:0] dt, input string rq);
        wait_idle();
        chk(nbits == 8 * (tx + rx), "R7", "rising edge count", 32'(nbits), 32'(8 * (tx + rx)));
        chk(cs_falls == 1, "R8", "one cs pulse", 32'(cs_falls), 32'h1);
        chk((t_rise1 - t_rise0) == CLK_DIV * TCLK, "R7", "sclk period ns",
            32'(int'(t_rise1 - t_rise0)), 32'(CLK_DIV * 10));
        chk((t_cs_rise - t_last_fall) == CLK_DIV * TCLK, "R8", "cs release delay ns",
            32'(int'(t_cs_rise - t_last_fall)), 32'(CLK_DIV * 10));
        for (int i = 0; i < tx; i++)
            chk(got[i] == exp_tx(c, dt, i), rq, $sformatf("tx byte %0d", i),
                {24'd0, got[i]}, {24'd0, exp_tx(c, dt, i)});
    endtask

    task automatic xfer(input int tx, input int rx, input logic [31:0] c,
                        input logic [31:0] dt, input string rq);
        wr(2'd1, c);
        wr(2'd2, dt);
        launch(tx, rx);
        finish(tx, rx, c, dt, rq);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        logic [31:0] v;
        rd(2'd0, v); chk(v == 32'h0, "R1", "ctrl after reset", v, 32'h0);
        rd(2'd1, v); chk(v == 32'h0, "R1", "cmd after reset", v, 32'h0);
        rd(2'd2, v); chk(v == 32'h0, "R1", "data after reset", v, 32'h0);
        chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R1", "pins after reset",
            {30'd0, spi_cs_n, spi_sclk}, 32'h2);
    endtask

    task automatic t_write_enable();
        logic [31:0] v;
        xfer(1, 0, 32'h0000_0006, 32'hDEAD_BEEF, "R3");
        rd(2'd2, v); chk(v == 32'hDEAD_BEEF, "R6", "data kept, rx=0", v, 32'hDEAD_BEEF);
        rd(2'd0, v); chk(v == 32'h0000_0001, "R2", "ctrl readback", v, 32'h1);
    endtask

    task automatic t_status();
        logic [31:0] v;
        xfer(1, 1, 32'h0000_0005, 32'hFFFF_FFFF, "R3");
        rd(2'd2, v); chk(v == exp_rx(1, 1), "R5", "status byte, upper zero", v, exp_rx(1, 1));
    endtask

    task automatic t_signature();
        logic [31:0] v;
        xfer(4, 1, 32'h1234_56AB, 32'h0, "R3");
        rd(2'd2, v); chk(v == exp_rx(4, 1), "R5", "signature byte", v, exp_rx(4, 1));
    endtask

    task automatic t_program();
        logic [31:0] v;
        xfer(8, 0, 32'hA0B0_C002, 32'h4433_2211, "R4");
        rd(2'd2, v); chk(v == 32'h4433_2211, "R6", "data kept after program", v, 32'h4433_2211);
    endtask

    task automatic t_read4();
        logic [31:0] v;
        xfer(4, 4, 32'h0001_0203, 32'h0, "R3");
        rd(2'd2, v); chk(v == exp_rx(4, 4), "R5", "four byte read", v, exp_rx(4, 4));
    endtask

    task automatic t_long_rx();
        logic [31:0] v;
        xfer(1, 6, 32'h0000_009F, 32'h0, "R3");
        rd(2'd2, v); chk(v == exp_rx(1, 6), "R5", "bytes past fourth dropped", v, exp_rx(1, 6));
    endtask

    task automatic t_long_tx();
        xfer(10, 0, 32'h5566_7702, 32'h8899_AABB, "R4");
    endtask

    task automatic t_busy_writes();
        logic [31:0] v;
        wr(2'd1, 32'h1122_3302);
        wr(2'd2, 32'hCAFE_F00D);
        launch(8, 2);
        repeat (30) @(negedge clk);
        wr(2'd1, 32'h0000_00C7);
        wr(2'd2, 32'h0BAD_0BAD);
        wr(2'd0, 32'h0000_0131);
        finish(8, 2, 32'h1122_3302, 32'hCAFE_F00D, "R9");
        repeat (100) @(negedge clk);
        chk(cs_falls == 1, "R9", "start while busy ignored", 32'(cs_falls), 32'h1);
        rd(2'd1, v); chk(v == 32'h0000_00C7, "R9", "cmd took busy write", v, 32'hC7);
        rd(2'd0, v); chk(v == 32'h0000_0031, "R9", "ctrl took busy write", v, 32'h31);
        rd(2'd2, v); chk(v == exp_rx(8, 2), "R5", "rx after busy writes", v, exp_rx(8, 2));
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_write_enable();
        t_status();
        t_signature();
        t_program();
        t_read4();
        t_long_rx();
        t_long_tx();
        t_busy_writes();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule